// File: doc/BRIEF.md
# Multi-Word Nonvolatile Store Read Sequencer

This block fetches a run of consecutive 16-bit words from a word-addressed nonvolatile store. The store offers only a single-word command/response port. A host supplies a starting word offset and a word count, then pulses a go strobe. The block first checks the range against the store size. An illegal range gets an error pulse and causes no access at all. A legal range is fetched one word at a time. For each word the block sends a command carrying the word address and a start flag. It then polls the response for a done flag at a fixed interval and gives up after a fixed number of attempts.

Each returned word leaves on a stream output as a one-cycle valid pulse, together with its word address. The last word's valid pulse coincides with the completion pulse. The first word that never reports done ends the burst with a timeout error code, and no further command is sent. The attempt count, the poll spacing in clock cycles and the store size are parameters. With a 250 MHz clock, the default spacing is 5 µs.

Top module: `nvm_burst_reader`

## Requirements
- R1: After reset, busy_o, done_o, err_o, word_valid_o and req_o are low and err_code_o is 0.
- R2: A go strobe with start_off_i >= DEPTH_WORDS produces err_o with err_code_o = 1 in the next cycle. No req_o is issued and busy_o stays low.
- R3: A go strobe with word_cnt_i > DEPTH_WORDS - start_off_i (and the offset in range) is rejected as in R2.
- R4: A go strobe with word_cnt_i = 0 is rejected as in R2.
- R5: Each access is a one-cycle req_o pulse. cmd_o holds the word address in bits starting at bit 2, bit 0 is set as the start flag, and all other bits are 0. Addresses run from start_off_i upward, one per word.
- R6: The done flag is rsp_i bit 1. It is first sampled in the cycle after req_o and then every POLL_GAP cycles, for at most POLL_TRIES samples. A store whose done flag rises L >= 1 cycles after the request edge succeeds exactly when L <= (POLL_TRIES-1)*POLL_GAP.
- R7: If no sample shows done, err_o pulses with err_code_o = 2 and busy_o falls. No further req_o is issued, and no word_valid_o follows the words already delivered.
- R8: Each fetched word is output as a one-cycle word_valid_o with word_data_o = rsp_i[31:16] and word_addr_o = its address, in ascending order, once per word.
- R9: The final word's word_valid_o and done_o pulse in the same cycle, and busy_o is low in that cycle.
- R10: go_i while busy_o is high is ignored. The running burst keeps its addresses and word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start strobe |
| start_off_i | input | HOST_W | First word offset |
| word_cnt_i | input | HOST_W | Number of words |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Burst completed pulse |
| err_o | output | 1 | Burst failed pulse |
| err_code_o | output | 2 | 0 none, 1 bad range, 2 timeout |
| word_valid_o | output | 1 | Output word valid pulse |
| word_addr_o | output | AW | Address of output word |
| word_data_o | output | WORD_W | Output word |
| req_o | output | 1 | Command strobe to the store |
| cmd_o | output | BUS_W | Command: address field and start flag |
| rsp_i | input | BUS_W | Response: done flag and data field |

## Verification
The final word's valid pulse and the completion pulse are produced by the same edge. Every legal burst of the near-exhaustive offset/count sweep therefore provokes both at once, including bursts of one word and bursts that end at the last address. The bench judges this at that sample: done_o must appear together with word_valid_o, and busy_o must be low. It also requires that the number of words and requests equals the count. The other coincidence is the timeout error arriving in place of a word. A store latency one cycle past the success limit provokes it, and the bench requires an error with no extra word or request.

// File: rtl/nvmrd_pkg.sv
package nvmrd_pkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_RANGE   = 2'd1,
    ERR_TIMEOUT = 2'd2
  } rd_err_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_POLL  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/nvmrd_range_chk.sv
module nvmrd_range_chk #(
  parameter int DEPTH_WORDS = 64,
  parameter int HOST_W      = 16
) (
  input  logic [HOST_W-1:0] off_i,
  input  logic [HOST_W-1:0] cnt_i,
  output logic              ok_o
);
  localparam logic [HOST_W:0] DEPTH_X = (HOST_W+1)'(DEPTH_WORDS);

  logic [HOST_W:0] off_x;
  logic [HOST_W:0] cnt_x;
  logic [HOST_W:0] room;
  logic            off_ok;
  logic            cnt_nz;
  logic            cnt_fits;

  always_comb begin
    off_x    = {1'b0, off_i};
    cnt_x    = {1'b0, cnt_i};
    off_ok   = (off_x < DEPTH_X);
    room     = off_ok ? (DEPTH_X - off_x) : '0;
    cnt_nz   = (cnt_x != '0);
    cnt_fits = (cnt_x <= room);
    ok_o     = off_ok & cnt_nz & cnt_fits;
  end
endmodule

// File: rtl/nvmrd_rsp_if.sv
module nvmrd_rsp_if #(
  parameter int AW        = 6,
  parameter int WORD_W    = 16,
  parameter int BUS_W     = 32,
  parameter int ADDR_LSB  = 2,
  parameter int START_BIT = 0,
  parameter int DONE_BIT  = 1,
  parameter int DATA_LSB  = 16
) (
  input  logic [AW-1:0]     addr_i,
  input  logic [BUS_W-1:0]  rsp_i,
  output logic [BUS_W-1:0]  cmd_o,
  output logic              done_o,
  output logic [WORD_W-1:0] data_o
);
  logic rsp_unused;

  always_comb begin
    cmd_o                   = '0;
    cmd_o[ADDR_LSB +: AW]   = addr_i;
    cmd_o[START_BIT]        = 1'b1;
  end

  assign done_o     = rsp_i[DONE_BIT];
  assign data_o     = rsp_i[DATA_LSB +: WORD_W];
  assign rsp_unused = ^rsp_i;
endmodule

// File: rtl/nvmrd_poll_timer.sv
module nvmrd_poll_timer #(
  parameter int POLL_TRIES = 100000,
  parameter int POLL_GAP   = 1250,
  localparam int TW = $clog2(POLL_TRIES + 1),
  localparam int GW = $clog2(POLL_GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic run_i,
  input  logic hit_i,
  output logic sample_o,
  output logic last_try_o
);
  localparam logic [GW-1:0] GAP_RELOAD = GW'(POLL_GAP - 1);
  localparam logic [TW-1:0] TRY_LAST   = TW'(POLL_TRIES - 1);

  logic [GW-1:0] gap_q, gap_d;
  logic [TW-1:0] try_q, try_d;
  logic          miss;
  logic          cnt_en;

  assign sample_o   = run_i & (gap_q == '0);
  assign last_try_o = (try_q == TRY_LAST);
  assign miss       = sample_o & ~hit_i;

  always_comb begin
    gap_d  = gap_q;
    try_d  = try_q;
    cnt_en = 1'b0;
    if (arm_i) begin
      gap_d  = '0;
      try_d  = '0;
      cnt_en = 1'b1;
    end else if (miss) begin
      gap_d  = GAP_RELOAD;
      try_d  = try_q + 1'b1;
      cnt_en = 1'b1;
    end else if (run_i && (gap_q != '0)) begin
      gap_d  = gap_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      try_q <= '0;
    end else if (cnt_en) begin
      gap_q <= gap_d;
      try_q <= try_d;
    end
  end
endmodule

// File: rtl/nvm_burst_reader.sv
module nvm_burst_reader
  import nvmrd_pkg::*;
#(
  parameter int DEPTH_WORDS = 64,
  parameter int HOST_W      = 16,
  parameter int WORD_W      = 16,
  parameter int BUS_W       = 32,
  parameter int ADDR_LSB    = 2,
  parameter int START_BIT   = 0,
  parameter int DONE_BIT    = 1,
  parameter int DATA_LSB    = 16,
  parameter int POLL_TRIES  = 100000,
  parameter int POLL_GAP    = 1250,
  localparam int AW = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [HOST_W-1:0] start_off_i,
  input  logic [HOST_W-1:0] word_cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic              word_valid_o,
  output logic [AW-1:0]     word_addr_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic              req_o,
  output logic [BUS_W-1:0]  cmd_o,
  input  logic [BUS_W-1:0]  rsp_i
);
  rd_state_e         state_q, state_d;
  logic [AW-1:0]     base_q, base_d;
  logic [AW-1:0]     idx_q, idx_d;
  logic [AW-1:0]     last_q, last_d;
  logic              ctx_en;

  logic              wv_q, wv_d;
  logic [AW-1:0]     waddr_q, waddr_d;
  logic [WORD_W-1:0] wdata_q, wdata_d;
  logic              word_en;

  logic              done_q, done_d;
  logic              err_q, err_d;
  rd_err_e           code_q, code_d;

  logic              range_ok;
  logic [AW-1:0]     cur_addr;
  logic              rsp_done;
  logic [WORD_W-1:0] rsp_data;
  logic              sample;
  logic              last_try;

  assign cur_addr = base_q + idx_q;

  nvmrd_range_chk #(
    .DEPTH_WORDS (DEPTH_WORDS),
    .HOST_W      (HOST_W)
  ) u_range (
    .off_i (start_off_i),
    .cnt_i (word_cnt_i),
    .ok_o  (range_ok)
  );

  nvmrd_rsp_if #(
    .AW        (AW),
    .WORD_W    (WORD_W),
    .BUS_W     (BUS_W),
    .ADDR_LSB  (ADDR_LSB),
    .START_BIT (START_BIT),
    .DONE_BIT  (DONE_BIT),
    .DATA_LSB  (DATA_LSB)
  ) u_rsp (
    .addr_i (cur_addr),
    .rsp_i  (rsp_i),
    .cmd_o  (cmd_o),
    .done_o (rsp_done),
    .data_o (rsp_data)
  );

  nvmrd_poll_timer #(
    .POLL_TRIES (POLL_TRIES),
    .POLL_GAP   (POLL_GAP)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (state_q == ST_ISSUE),
    .run_i      (state_q == ST_POLL),
    .hit_i      (rsp_done),
    .sample_o   (sample),
    .last_try_o (last_try)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    idx_d   = idx_q;
    last_d  = last_q;
    ctx_en  = 1'b0;
    wv_d    = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    word_en = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    code_d  = code_q;
    unique case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          if (range_ok) begin
            base_d  = start_off_i[AW-1:0];
            idx_d   = '0;
            last_d  = AW'(word_cnt_i - 1'b1);
            ctx_en  = 1'b1;
            code_d  = ERR_NONE;
            state_d = ST_ISSUE;
          end else begin
            err_d  = 1'b1;
            code_d = ERR_RANGE;
          end
        end
      end
      ST_ISSUE: begin
        state_d = ST_POLL;
      end
      ST_POLL: begin
        if (sample) begin
          if (rsp_done) begin
            wv_d    = 1'b1;
            waddr_d = cur_addr;
            wdata_d = rsp_data;
            word_en = 1'b1;
            if (idx_q == last_q) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              idx_d   = idx_q + 1'b1;
              ctx_en  = 1'b1;
              state_d = ST_ISSUE;
            end
          end else if (last_try) begin
            err_d   = 1'b1;
            code_d  = ERR_TIMEOUT;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wv_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      state_q <= state_d;
      wv_q    <= wv_d;
      done_q  <= done_d;
      err_q   <= err_d;
      code_q  <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (ctx_en) begin
      base_q <= base_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (word_en) begin
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign req_o        = (state_q == ST_ISSUE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign err_code_o   = code_q;
  assign word_valid_o = wv_q;
  assign word_addr_o  = waddr_q;
  assign word_data_o  = wdata_q;
endmodule

// File: rtl/nvmrd_chk.sv
module nvmrd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] err_code_o,
  input logic       word_valid_o,
  input logic       req_o
);
  AST_REQ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> busy_o);                                            // R5
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);                                            // R5
  AST_RANGE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && err_code_o == 2'd1) |-> ($past(go_i) && !$past(busy_o) && !busy_o)); // R2
  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!req_o && !word_valid_o));                         // R7
  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));                                          // R7
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (word_valid_o && !busy_o));                        // R9
  AST_BUSY_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o || err_o));                         // R9
  AST_WORD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> $past(busy_o));                              // R8
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && busy_o) |=> !(err_o && err_code_o == 2'd1));         // R10
endmodule

bind nvm_burst_reader nvmrd_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .go_i         (go_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .err_code_o   (err_code_o),
  .word_valid_o (word_valid_o),
  .req_o        (req_o)
);

// File: tb/nvm_burst_reader_tb_top.sv
`timescale 1ns/1ps
module nvm_burst_reader_tb_top;
  localparam int DEPTH = 16;
  localparam int TRIES = 4;
  localparam int GAP   = 3;
  localparam int AW    = 4;
  localparam int LMAX  = (TRIES - 1) * GAP;

  logic        clk;
  logic        rst_n;
  logic        go;
  logic [15:0] start_off;
  logic [15:0] word_cnt;
  logic        busy, done, err, wvalid, req;
  logic [1:0]  code;
  logic [AW-1:0] waddr;
  logic [15:0] wdata;
  logic [31:0] cmd;
  logic [31:0] rsp;

  int checks = 0;
  int fails  = 0;

  // store model state
  int        lat_cfg   = 1;
  int        stall_adr = -1;
  int        dev_addr;
  int        lat_ctr;
  logic      dev_done;
  int        exp_off   = 0;
  int        req_seen  = 0;

  nvm_burst_reader #(
    .DEPTH_WORDS (DEPTH),
    .POLL_TRIES  (TRIES),
    .POLL_GAP    (GAP)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go),
    .start_off_i  (start_off),
    .word_cnt_i   (word_cnt),
    .busy_o       (busy),
    .done_o       (done),
    .err_o        (err),
    .err_code_o   (code),
    .word_valid_o (wvalid),
    .word_addr_o  (waddr),
    .word_data_o  (wdata),
    .req_o        (req),
    .cmd_o        (cmd),
    .rsp_i        (rsp)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] mem_word(int a);
    return 16'((32'hC35A ^ (a * 257) ^ (a << 11)));
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // store: done rises lat_cfg edges after the request edge; junk in unused bits
  assign rsp = {mem_word(dev_addr), 14'h1555, dev_done, 1'b1};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_done <= 1'b0;
      lat_ctr  <= 0;
      dev_addr <= 0;
    end else if (req) begin
      dev_addr <= int'(cmd[31:2]);
      dev_done <= 1'b0;
      lat_ctr  <= 1;
    end else if (lat_ctr != 0 && !dev_done) begin
      if (lat_ctr == lat_cfg && dev_addr != stall_adr) dev_done <= 1'b1;
      lat_ctr <= lat_ctr + 1;
    end
  end

  // R5: every command carries the next expected address and the start flag
  always @(posedge clk) begin
    if (rst_n && req) begin
      chk(cmd == (32'((exp_off + req_seen) << 2) | 32'd1), "R5", "command word",
          int'(cmd), ((exp_off + req_seen) << 2) | 1);
      req_seen++;
    end
  end

  int  r_words;
  bit  r_done, r_err, r_vat_done, r_busy_end;
  int  r_code;

  task automatic run_burst(int off, int cnt, int lat, int stall, bit inject);
    bit reject, fin;
    int n_ok, cyc;
    string rtag;
    reject = (off >= DEPTH) || (cnt == 0) || (cnt > DEPTH - off);
    if (reject) n_ok = 0;
    else if (lat > LMAX) n_ok = 0;
    else if (stall >= off && stall < off + cnt) n_ok = stall - off;
    else n_ok = cnt;
    exp_off = off; req_seen = 0; lat_cfg = lat; stall_adr = stall;
    r_words = 0; r_done = 0; r_err = 0; r_vat_done = 0; r_busy_end = 1; r_code = -1;
    @(negedge clk);
    go = 1'b1; start_off = 16'(off); word_cnt = 16'(cnt);
    @(negedge clk);
    go = 1'b0;
    fin = 0; cyc = 0;
    while (!fin && cyc < 600) begin
      go = 1'b0;
      if (wvalid) begin
        chk(int'(waddr) == off + r_words, "R8", "word address", int'(waddr), off + r_words);
        chk(wdata == mem_word(off + r_words), "R8", "word data", int'(wdata),
            int'(mem_word(off + r_words)));
        r_words++;
      end
      if (done || err) begin
        fin = 1; r_done = done; r_err = err; r_code = int'(code);
        r_vat_done = wvalid; r_busy_end = busy;
      end else begin
        if (inject && cyc == 2) begin
          go = 1'b1; start_off = 16'd0; word_cnt = 16'd1;
        end
        @(negedge clk);
        cyc++;
      end
    end
    go = 1'b0;
    if (!fin) chk(0, "R9", "burst never ended", cyc, 0);
    if (reject) begin
      rtag = (off >= DEPTH) ? "R2" : (cnt == 0) ? "R4" : "R3";
      chk(r_err && r_code == 1 && cyc == 0, rtag, "range error pulse", r_code, 1);
      chk(req_seen == 0 && !r_busy_end, rtag, "no access on reject", req_seen, 0);
    end else if (n_ok < cnt) begin
      chk(r_err && r_code == 2, "R7", "timeout code", r_code, 2);
      chk(r_words == n_ok, "R7", "words before timeout", r_words, n_ok);
      chk(req_seen == n_ok + 1, "R7", "requests issued", req_seen, n_ok + 1);
    end else begin
      chk(r_done && !r_err, "R9", "completion pulse", int'(r_done), 1);
      chk(r_vat_done && !r_busy_end, "R9", "last word with done, busy low",
          int'(r_vat_done), 1);
      chk(r_words == cnt, "R8", "word count", r_words, cnt);
      chk(req_seen == cnt, "R5", "request count", req_seen, cnt);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4.0 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; start_off = '0; word_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !wvalid && !req && code == 2'd0, "R1", "idle outputs",
        int'({busy, done, err, wvalid, req, code}), 0);

    // near-exhaustive sweep of offset and count, R2 R3 R4 R5 R8 R9
    for (int off = 0; off <= DEPTH + 1; off++)
      for (int cnt = 0; cnt <= DEPTH + 1; cnt++)
        run_burst(off, cnt, 1 + ((off + cnt) % 4), -1, 1'b0);

    // large offsets beyond the address width, R2
    run_burst(DEPTH + 16, 1, 1, -1, 1'b0);
    run_burst(16'hFFFF, 16'hFFFF, 1, -1, 1'b0);

    // R6: latency at the last sample succeeds, one more times out
    run_burst(2, 3, LMAX, -1, 1'b0);
    chk(r_done && r_words == 3, "R6", "latency at limit succeeds", r_words, 3);
    run_burst(2, 3, LMAX + 1, -1, 1'b0);
    chk(r_err && r_code == 2 && r_words == 0, "R6", "latency past limit times out", r_code, 2);

    // R7: store stalls mid-burst
    run_burst(3, 6, 2, 5, 1'b0);
    run_burst(0, DEPTH, 5, DEPTH - 1, 1'b0);
    run_burst(7, 1, 3, 7, 1'b0);

    // R10: go pulse during a burst is ignored
    run_burst(4, 5, 2, -1, 1'b1);
    chk(r_done && r_words == 5 && req_seen == 5, "R10", "burst unchanged by go", r_words, 5);
    run_burst(10, 6, 4, -1, 1'b1);
    chk(r_done && r_words == 6, "R10", "burst to end unchanged by go", r_words, 6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule